// File: doc/BRIEF.md
# I2C Transmit Master with Byte Counter

This block drives an I2C bus as a transmit-only master. Software supplies a 7-bit target address, a byte count and payload bytes through a two-entry transmit queue. It then pulses a go input. The engine produces the start condition, the address byte with the write bit, the data bytes and the stop condition on open-drain SCL and SDA. Both lines are driven through active-high pull-low enables. The engine samples the receiver's acknowledge after every byte.

The count normally ends a transfer by itself. The value 0xFF turns the count off, and the transfer then runs until a stop request is taken at a byte boundary. A restart request can be armed at any point while the master is enabled. When the transfer ends with a restart armed, the bus gets a repeated start, and a fresh address and count are taken from the inputs. If the queue is empty when the next byte is due, the master holds SCL low after the acknowledge until software writes a byte. A legacy option aborts the transfer instead. Events are reported in a sticky status byte whose bits are cleared by writing ones.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset, SCL and SDA are released (both enables 0), busy is 0 and status is 0x00.
- R2: A transfer is a start condition, then the byte {address,0}, then the data bytes, all sent MSB first. Each byte takes 9 SCL clocks, and the ninth clock samples the acknowledge. Rising SCL edges within a byte are 4*(clkDiv+1) clock cycles apart.
- R3: With a count N from 0 to 254, exactly N data bytes follow the address, and then a stop is issued. N=0 sends the address only.
- R4: With count 0xFF, the master does not stop on its own. A stopReq pulse ends the transfer with a stop after the acknowledge of the byte in flight, or at once if SCL is being held.
- R5: Status bit 6 (0x40) is set when a byte is taken from the queue and the queue is left empty.
- R6: If the queue is empty when the next byte is due, SCL is held low and SDA is released after the acknowledge. The transfer resumes with no other action once a byte is written.
- R7: A restartReq pulse while busy makes the transfer end in a repeated start instead of a stop. The address and count inputs are then reloaded, and the new transfer is then treated like any other.
- R8: Status bit 4 (0x10) is set when a transfer concludes, at a stop or at a repeated start. Busy falls together with the stop.
- R9: With legacyMode=1 and the queue empty when the next byte is due, the master issues a stop and sets status bits 3 (0x08) and 5 (0x20).
- R10: A NACK on any byte sets status bits 2 (0x04) and 5 (0x20), and a stop is issued.
- R11: The queue holds 2 bytes. A write with fifoWrWide=0 pushes fifoWrData[7:0]. A write with fifoWrWide=1 pushes [7:0] and then [15:8]. Bytes that find the queue full are dropped.
- R12: Writing 1 to a bit of statusClr clears that status bit, and writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R13: A restartReq pulse while busy is 0 has no effect, so the next transfer ends with a plain stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clkDiv | input | 8 | Quarter-bit period minus one, in clock cycles |
| legacyMode | input | 1 | Abort instead of stretching on an empty queue |
| tgtAddr | input | 7 | Target address, taken at go and at a repeated start |
| xferCount | input | 8 | Data byte count (0xFF = unlimited), taken at go and at a repeated start |
| xferGo | input | 1 | Start pulse, ignored while busy |
| stopReq | input | 1 | Stop request pulse for unlimited transfers |
| restartReq | input | 1 | Arms a repeated start while busy |
| fifoWrEn | input | 1 | Queue write strobe |
| fifoWrWide | input | 1 | Push two bytes instead of one |
| fifoWrData | input | 16 | Queue write data |
| statusClr | input | 8 | Write-one-to-clear mask for status |
| sdaIn | input | 1 | Sampled SDA line level |
| sclOe | output | 1 | Pull SCL low |
| sdaOe | output | 1 | Pull SDA low |
| busy | output | 1 | Master enabled, transfer in progress |
| status | output | 8 | Sticky event flags |

## Verification
A wrong count register shows on the bus within one byte time. The stop or repeated start arrives one byte early or late, and the event stream seen by the bench's bus receiver no longer matches. A lost queue entry or a wrong pop order shows as a wrong data byte at its ninth SCL clock. A stuck stretch state shows as SCL held low long after a byte was written. A wrong restart or stop flag shows as the wrong bus condition at the end of the frame. The bench decodes start, repeated start, stop and every byte from the two line enables and compares each against a queue of expected events as it happens. The status byte is checked once each transfer has ended.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int STAT_W = 8;

  localparam int ST_NACK    = 2;
  localparam int ST_BUFERR  = 3;
  localparam int ST_MCOMP   = 4;
  localparam int ST_MERR    = 5;
  localparam int ST_XMTSERV = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SEND,
    ST_STRETCH,
    ST_STOP,
    ST_RSTART
  } mstState_t;

  typedef struct packed {
    logic loadAddr;
    logic loadData;
    logic shiftBit;
    logic loadCount;
    logic decCount;
    logic tickClr;
  } dpStrobe_t;

endpackage

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int CNT_W      = 8,
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  dpStrobe_t         strb,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [CNT_W-1:0]  countIn,
  input  logic              wrEn,
  input  logic              wrWide,
  input  logic [15:0]       wrData,
  output logic              tick,
  output logic              txBit,
  output logic              fifoEmpty,
  output logic              xmtEmptied,
  output logic              cntZero,
  output logic              cntLast,
  output logic              cntUnlimited
);

  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(FIFO_DEPTH);
  localparam int WR_BYTES = 2;

  // quarter-bit tick generator
  logic [DIV_W-1:0] divCnt;
  assign tick = busy && (divCnt == clkDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  divCnt <= '0;
    else if (strb.tickClr || tick) divCnt <= '0;
    else                        divCnt <= divCnt + DIV_W'(1);
  end

  // transmit queue
  logic [BYTE_W-1:0] mem     [FIFO_DEPTH];
  logic [BYTE_W-1:0] memNext [FIFO_DEPTH];
  logic [LVL_W-1:0]  level, lvlNext;
  logic              doPop;

  assign doPop     = strb.loadData && (level != '0);
  assign fifoEmpty = (level == '0);

  always_comb begin
    memNext = mem;
    lvlNext = level;
    if (doPop) begin
      for (int i = 0; i < FIFO_DEPTH - 1; i++) memNext[i] = mem[i+1];
      lvlNext = level - LVL_W'(1);
    end
    for (int k = 0; k < WR_BYTES; k++) begin
      if (wrEn && (k == 0 || wrWide) && (lvlNext < DEPTH_L)) begin
        memNext[lvlNext[PTR_W-1:0]] = wrData[BYTE_W*k +: BYTE_W];
        lvlNext = lvlNext + LVL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < FIFO_DEPTH; i++) mem[i] <= '0;
      level <= '0;
    end else begin
      mem   <= memNext;
      level <= lvlNext;
    end
  end

  assign xmtEmptied = doPop && (lvlNext == '0);

  // transmit shift register, MSB first
  logic [BYTE_W-1:0] shReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shReg <= '0;
    else if (strb.loadAddr) shReg <= {addrIn, 1'b0};
    else if (strb.loadData) shReg <= mem[0];
    else if (strb.shiftBit) shReg <= {shReg[BYTE_W-2:0], 1'b0};
  end
  assign txBit = shReg[BYTE_W-1];

  // data byte counter
  logic [CNT_W-1:0] cnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strb.loadCount) cnt <= countIn;
    else if (strb.decCount)  cnt <= cnt - CNT_W'(1);
  end
  assign cntZero      = (cnt == '0);
  assign cntLast      = (cnt == CNT_W'(1));
  assign cntUnlimited = &cnt;

  // R11: control only pops a non-empty queue
  a_r11_pop_not_empty: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadData |-> (level != '0));
  // R11: queue never holds more than its depth
  a_r11_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    level <= DEPTH_L);
  // R3/R4: count is never decremented at zero or in unlimited mode
  a_r3_dec_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decCount && !strb.loadCount) |-> (cnt != '0 && !(&cnt)));

endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferGo,
  input  logic              stopReq,
  input  logic              restartReq,
  input  logic              legacyMode,
  input  logic              sdaIn,
  input  logic [STAT_W-1:0] statusClr,
  input  logic              tick,
  input  logic              txBit,
  input  logic              fifoEmpty,
  input  logic              xmtEmptied,
  input  logic              cntZero,
  input  logic              cntLast,
  input  logic              cntUnlimited,
  output dpStrobe_t         strb,
  output logic              busy,
  output logic              sclOe,
  output logic              sdaOe,
  output logic [STAT_W-1:0] status
);

  localparam logic [3:0] ACK_BIT = 4'd8;

  mstState_t   state, stateN;
  logic [1:0]  phase, phaseN;
  logic [3:0]  bitIdx, bitN;
  logic        isAddr, isAddrN;
  logic        busyN;
  logic        stopArm, stopArmN;
  logic        restartArm, rstArmN;
  logic        lastDone;
  logic [STAT_W-1:0] statSet;

  always_comb begin
    stateN   = state;
    phaseN   = phase;
    bitN     = bitIdx;
    isAddrN  = isAddr;
    busyN    = busy;
    stopArmN = stopArm | (stopReq & busy);
    rstArmN  = restartArm | (restartReq & busy);
    statSet  = '0;
    strb     = '0;
    lastDone = 1'b0;
    statSet[ST_XMTSERV] = xmtEmptied;

    unique case (state)
      ST_IDLE: begin
        strb.tickClr = 1'b1;
        stopArmN = 1'b0;
        rstArmN  = 1'b0;
        if (xferGo) begin
          strb.loadAddr  = 1'b1;
          strb.loadCount = 1'b1;
          busyN  = 1'b1;
          stateN = ST_START;
          phaseN = 2'd0;
        end
      end

      ST_START, ST_RSTART: begin
        if (tick) begin
          phaseN = phase + 2'd1;
          if (phase == 2'd3) begin
            stateN  = ST_SEND;
            bitN    = 4'd0;
            isAddrN = 1'b1;
          end
        end
      end

      ST_SEND: begin
        if (tick) begin
          phaseN = phase + 2'd1;
          if (phase == 2'd3) begin
            if (bitIdx != ACK_BIT) begin
              strb.shiftBit = 1'b1;
              bitN = bitIdx + 4'd1;
            end else if (sdaIn) begin
              statSet[ST_NACK] = 1'b1;
              statSet[ST_MERR] = 1'b1;
              stateN = ST_STOP;
            end else begin
              if (!isAddr && !cntUnlimited) strb.decCount = 1'b1;
              lastDone = isAddr ? cntZero : cntLast;
              if (lastDone || stopArm) begin
                if (restartArm) begin
                  stateN = ST_RSTART;
                  strb.loadAddr  = 1'b1;
                  strb.loadCount = 1'b1;
                  statSet[ST_MCOMP] = 1'b1;
                  rstArmN  = 1'b0;
                  stopArmN = 1'b0;
                end else begin
                  stateN = ST_STOP;
                end
              end else if (!fifoEmpty) begin
                strb.loadData = 1'b1;
                bitN    = 4'd0;
                isAddrN = 1'b0;
              end else if (legacyMode) begin
                statSet[ST_BUFERR] = 1'b1;
                statSet[ST_MERR]   = 1'b1;
                stateN = ST_STOP;
              end else begin
                stateN = ST_STRETCH;
              end
            end
          end
        end
      end

      ST_STRETCH: begin
        strb.tickClr = 1'b1;
        phaseN = 2'd0;
        if (stopArm) begin
          stateN = ST_STOP;
        end else if (!fifoEmpty) begin
          strb.loadData = 1'b1;
          stateN  = ST_SEND;
          bitN    = 4'd0;
          isAddrN = 1'b0;
        end
      end

      ST_STOP: begin
        if (tick) begin
          phaseN = phase + 2'd1;
          if (phase == 2'd3) begin
            stateN   = ST_IDLE;
            busyN    = 1'b0;
            stopArmN = 1'b0;
            rstArmN  = 1'b0;
            statSet[ST_MCOMP] = 1'b1;
          end
        end
      end

      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phase      <= 2'd0;
      bitIdx     <= 4'd0;
      isAddr     <= 1'b0;
      busy       <= 1'b0;
      stopArm    <= 1'b0;
      restartArm <= 1'b0;
      status     <= '0;
    end else begin
      state      <= stateN;
      phase      <= phaseN;
      bitIdx     <= bitN;
      isAddr     <= isAddrN;
      busy       <= busyN;
      stopArm    <= stopArmN;
      restartArm <= rstArmN;
      status     <= (status & ~statusClr) | statSet;
    end
  end

  // line drive, 1 = pull low
  always_comb begin
    sclOe = 1'b0;
    sdaOe = 1'b0;
    unique case (state)
      ST_IDLE: ;
      ST_START: begin
        sclOe = (phase == 2'd3);
        sdaOe = (phase != 2'd0);
      end
      ST_SEND: begin
        sclOe = !phase[1];
        sdaOe = (bitIdx != ACK_BIT) && !txBit;
      end
      ST_STRETCH: sclOe = 1'b1;
      ST_STOP: begin
        sclOe = (phase == 2'd0);
        sdaOe = (phase != 2'd3);
      end
      ST_RSTART: begin
        sclOe = (phase == 2'd0) || (phase == 2'd3);
        sdaOe = phase[1];
      end
      default: ;
    endcase
  end

  // R1: bus released whenever the master is not enabled
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclOe && !sdaOe));
  // R6: a written byte releases a stretched clock on the next edge
  a_r6_stretch_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STRETCH && !fifoEmpty && !stopArm) |=> (state == ST_SEND && bitIdx == 4'd0));
  // R13: a restart request while disabled is not remembered
  a_r13_restart_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && restartReq) |=> !restartArm);
  // R8: the end of a transfer always leaves the complete flag set
  a_r8_busy_fall_mcomp: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> status[ST_MCOMP]);
  // R12: a cleared flag with no new event goes to zero
  a_r12_w1c_mcomp: assert property (@(posedge clk) disable iff (!rstN)
    (statusClr[ST_MCOMP] && !statSet[ST_MCOMP]) |=> !status[ST_MCOMP]);

endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master
  import i2cm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  clkDiv,
  input  logic        legacyMode,
  input  logic [6:0]  tgtAddr,
  input  logic [7:0]  xferCount,
  input  logic        xferGo,
  input  logic        stopReq,
  input  logic        restartReq,
  input  logic        fifoWrEn,
  input  logic        fifoWrWide,
  input  logic [15:0] fifoWrData,
  input  logic [7:0]  statusClr,
  input  logic        sdaIn,
  output logic        sclOe,
  output logic        sdaOe,
  output logic        busy,
  output logic [7:0]  status
);

  dpStrobe_t strb;
  logic tick, txBit, fifoEmpty, xmtEmptied;
  logic cntZero, cntLast, cntUnlimited;

  i2cm_datapath #(
    .DIV_W      (8),
    .CNT_W      (8),
    .FIFO_DEPTH (2)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .busy         (busy),
    .strb         (strb),
    .clkDiv       (clkDiv),
    .addrIn       (tgtAddr),
    .countIn      (xferCount),
    .wrEn         (fifoWrEn),
    .wrWide       (fifoWrWide),
    .wrData       (fifoWrData),
    .tick         (tick),
    .txBit        (txBit),
    .fifoEmpty    (fifoEmpty),
    .xmtEmptied   (xmtEmptied),
    .cntZero      (cntZero),
    .cntLast      (cntLast),
    .cntUnlimited (cntUnlimited)
  );

  i2cm_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .xferGo       (xferGo),
    .stopReq      (stopReq),
    .restartReq   (restartReq),
    .legacyMode   (legacyMode),
    .sdaIn        (sdaIn),
    .statusClr    (statusClr),
    .tick         (tick),
    .txBit        (txBit),
    .fifoEmpty    (fifoEmpty),
    .xmtEmptied   (xmtEmptied),
    .cntZero      (cntZero),
    .cntLast      (cntLast),
    .cntUnlimited (cntUnlimited),
    .strb         (strb),
    .busy         (busy),
    .sclOe        (sclOe),
    .sdaOe        (sdaOe),
    .status       (status)
  );

endmodule

// File: tb/i2c_tx_master_tb.sv
module i2c_tx_master_tb;

  localparam int EV_S  = 256;
  localparam int EV_SR = 257;
  localparam int EV_P  = 258;
  localparam int DIV   = 3;
  localparam int BIT_T = 4 * (DIV + 1);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  clkDiv = 8'(DIV);
  logic        legacyMode = 1'b0;
  logic [6:0]  tgtAddr = '0;
  logic [7:0]  xferCount = '0;
  logic        xferGo = 1'b0, stopReq = 1'b0, restartReq = 1'b0;
  logic        fifoWrEn = 1'b0, fifoWrWide = 1'b0;
  logic [15:0] fifoWrData = '0;
  logic [7:0]  statusClr = '0;
  logic        sdaIn;
  logic        sclOe, sdaOe, busy;
  logic [7:0]  status;

  logic        slaveOe = 1'b0;
  logic        nackData = 1'b0;

  assign sdaIn = !(sdaOe || slaveOe);

  i2c_tx_master u_dut (
    .clk(clk), .rstN(rstN), .clkDiv(clkDiv), .legacyMode(legacyMode),
    .tgtAddr(tgtAddr), .xferCount(xferCount), .xferGo(xferGo),
    .stopReq(stopReq), .restartReq(restartReq), .fifoWrEn(fifoWrEn),
    .fifoWrWide(fifoWrWide), .fifoWrData(fifoWrData), .statusClr(statusClr),
    .sdaIn(sdaIn), .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy), .status(status)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int monChecks = 0, monErrs = 0;
  int cyc = 0;
  bit done = 1'b0;
  int expQ[$];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      $display("FAIL watchdog: run hung, got cycle %0d exp below 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors + monErrs + 1, checks + monChecks + 1);
      $finish;
    end
  end

  // bus receiver model: decodes conditions and bytes, answers ACK/NACK
  logic prevScl, prevSda, sclL, sdaL, inFrame;
  int   bitCnt, frameByte, lastRise;
  logic [7:0] shByte;

  task automatic logEvent(input int v);
    int e;
    monChecks++;
    if (expQ.size() == 0) begin
      monErrs++;
      $display("FAIL R2/R3 unexpected bus event: got %0d exp none", v);
    end else begin
      e = expQ.pop_front();
      if (e != v) begin
        monErrs++;
        $display("FAIL R2/R3 bus event: got %0d exp %0d", v, e);
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      prevScl = 1'b1; prevSda = 1'b1; inFrame = 1'b0;
      bitCnt = 0; frameByte = 0; lastRise = 0; shByte = '0;
    end else begin
      sclL = !sclOe;
      sdaL = !(sdaOe || slaveOe);
      if (prevScl && sclL && prevSda && !sdaL) begin
        logEvent(inFrame ? EV_SR : EV_S);
        inFrame = 1'b1; bitCnt = 0; frameByte = 0; slaveOe = 1'b0;
      end else if (prevScl && sclL && !prevSda && sdaL) begin
        logEvent(EV_P);
        inFrame = 1'b0; bitCnt = 0;
      end else if (!prevScl && sclL && inFrame) begin
        if (bitCnt >= 1) begin
          monChecks++;
          if (cyc - lastRise != BIT_T) begin
            monErrs++;
            $display("FAIL R2 SCL period: got %0d exp %0d", cyc - lastRise, BIT_T);
          end
        end
        lastRise = cyc;
        if (bitCnt < 8) shByte = {shByte[6:0], sdaL};
        bitCnt++;
        if (bitCnt == 9) begin
          logEvent(int'(shByte));
          frameByte++;
          bitCnt = 0;
        end
      end else if (prevScl && !sclL) begin
        if (slaveOe) slaveOe = 1'b0;
        else if (bitCnt == 8) slaveOe = !(nackData && frameByte >= 1);
      end
      prevScl = sclL;
      prevSda = sdaL;
    end
  end

  task automatic check(input string tag, input int got, input int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s: got 0x%0h exp 0x%0h", tag, got, expv);
    end
  endtask

  task automatic wr8(input logic [7:0] b);
    @(negedge clk); fifoWrEn = 1'b1; fifoWrWide = 1'b0; fifoWrData = {8'h00, b};
    @(negedge clk); fifoWrEn = 1'b0;
  endtask

  task automatic wr16(input logic [15:0] w);
    @(negedge clk); fifoWrEn = 1'b1; fifoWrWide = 1'b1; fifoWrData = w;
    @(negedge clk); fifoWrEn = 1'b0; fifoWrWide = 1'b0;
  endtask

  task automatic go(input logic [6:0] a, input logic [7:0] n);
    @(negedge clk); tgtAddr = a; xferCount = n; xferGo = 1'b1;
    @(negedge clk); xferGo = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk); stopReq = 1'b1;
    @(negedge clk); stopReq = 1'b0;
  endtask

  task automatic pulseRestart();
    @(negedge clk); restartReq = 1'b1;
    @(negedge clk); restartReq = 1'b0;
  endtask

  task automatic clr(input logic [7:0] m);
    @(negedge clk); statusClr = m;
    @(negedge clk); statusClr = '0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic waitServ();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (status[6]) break;
    end
  endtask

  task automatic allSeen(input string tag);
    check(tag, expQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sclOe", int'(sclOe), 0);
    check("R1 sdaOe", int'(sdaOe), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 status", int'(status), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2/R3/R11: two bytes from one wide write, low byte first
    expQ = '{EV_S, 'hB4, 'h3C, 'hC3, EV_P};
    wr16(16'hC33C);
    go(7'h5A, 8'd2);
    waitIdle();
    allSeen("R3 two-byte transfer complete");
    check("R5/R8 status after transfer", int'(status), 'h50);

    // R12: write-one-to-clear, one bit at a time
    clr(8'h10);
    check("R12 clear mcomp only", int'(status), 'h40);
    clr(8'h40);
    check("R12 clear xmtserv", int'(status), 'h00);

    // R3: count zero sends address only
    expQ = '{EV_S, 'h22, EV_P};
    go(7'h11, 8'd0);
    waitIdle();
    allSeen("R3 count zero");
    check("R8 status count zero", int'(status), 'h10);
    clr(8'hFF);

    // R6: stretch on empty queue, release on write
    expQ = '{EV_S, 'h40, 'hA5, 'h5A, EV_P};
    wr8(8'hA5);
    go(7'h20, 8'd2);
    waitServ();
    repeat (300) @(negedge clk);
    check("R6 SCL held low", int'(sclOe), 1);
    check("R6 SDA released", int'(sdaOe), 0);
    check("R6 still busy", int'(busy), 1);
    wr8(8'h5A);
    waitIdle();
    allSeen("R6 resumed transfer");
    check("R5 status after stretch", int'(status), 'h50);
    clr(8'hFF);

    // R4: unlimited count, stop by request
    expQ = '{EV_S, 'h66, 'h11, 'h22, 'h33, EV_P};
    wr16(16'h2211);
    go(7'h33, 8'hFF);
    waitServ();
    repeat (300) @(negedge clk);
    check("R4 no self stop with 0xFF", int'(busy), 1);
    check("R4 clock held", int'(sclOe), 1);
    wr8(8'h33);
    repeat (20) @(negedge clk);
    pulseStop();
    waitIdle();
    allSeen("R4 stop request");
    check("R4 status", int'(status), 'h50);
    clr(8'hFF);

    // R7: restart armed early, new address and count reloaded
    expQ = '{EV_S, 'h60, 'h55, EV_SR, 'h62, 'h66, EV_P};
    wr16(16'h6655);
    go(7'h30, 8'd1);
    pulseRestart();
    tgtAddr = 7'h31; xferCount = 8'd1;
    waitIdle();
    allSeen("R7 repeated start sequence");
    check("R7 status", int'(status), 'h50);
    clr(8'hFF);

    // R13: restart request while disabled is ignored
    pulseRestart();
    expQ = '{EV_S, 'h1E, EV_P};
    go(7'h0F, 8'd0);
    waitIdle();
    allSeen("R13 no repeated start");
    check("R13 busy low", int'(busy), 0);
    check("R13 status", int'(status), 'h10);
    clr(8'hFF);

    // R10: data byte NACK
    nackData = 1'b1;
    expQ = '{EV_S, 'h80, 'h01, EV_P};
    wr8(8'h01);
    go(7'h40, 8'd1);
    waitIdle();
    allSeen("R10 stop after nack");
    check("R10 status", int'(status), 'h74);
    nackData = 1'b0;
    clr(8'hFF);

    // R9: legacy abort on empty queue
    legacyMode = 1'b1;
    expQ = '{EV_S, 'h14, 'h99, EV_P};
    wr8(8'h99);
    go(7'h0A, 8'd3);
    waitIdle();
    allSeen("R9 abort with stop");
    check("R9 status", int'(status), 'h78);
    check("R9 busy low", int'(busy), 0);
    legacyMode = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors + monErrs, checks + monChecks);
    $finish;
  end

endmodule